// File: doc/BRIEF.md
# Alternating-Orientation Transposition Buffer

This block turns a stream of N-lane vectors into the transposed stream, for use between the column pass and the row pass of a separable 2-D transform. Each valid input vector is one column or one row of an N×N block. After the first block has been taken in, each valid input produces one transposed output vector in the following cycle. Blocks can follow each other with no gap.

A single N×N array of register cells holds the data. Within one period of N valid inputs, the buffer reads a slot and writes the incoming vector into that same slot in the same cycle. The slot is a column during one period and a row during the next, and the orientation flips at every period boundary. Because of this, the array is the only storage. Data never moves between cells, and no second bank is needed. Each output lane is picked by a (2N−1):1 multiplexer that sees the cells of one row and one column of the array.

Top module: `xpose_alt_buffer`

## Requirements
- R1: While reset is high and in the cycle after it is released, `out_vld` is 0 and `out_vec` is 0. After reset, the first period uses column orientation and the slot index is 0.
- R2: `out_vld` stays 0 for the first N valid inputs after reset. It first goes high in the cycle after the (N+1)th valid input.
- R3: Lane j of a vector is held in bits [j*W +: W] of `in_vec` and `out_vec`. For the k-th valid input (0-based) with k ≥ N, set b = k div N and s = k mod N. Lane j of the output is then lane s of input number (b−1)*N + j.
- R4: The orientation flips after every N valid inputs, so a stream of three or more blocks with no gap comes out as one transposed block after another.
- R5: A cycle in which `in_vld` is 0 changes no state. In the next cycle `out_vld` is 0 and `out_vec` keeps its previous value. The transposition goes on correctly across such gaps.
- R6: Once the first N valid inputs have been taken, `out_vld` is 1 in exactly the cycles that follow a valid input.
- R7: Signed W-bit values pass through unchanged, including the most negative and most positive codes.
- R8: A reset in the middle of a block throws away the partly received data and starts the priming of R2 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input vector valid |
| in_vec | input | N*W | Input vector, lane j at bits [j*W +: W] |
| out_vld | output | 1 | Output vector valid (registered) |
| out_vec | output | N*W | Transposed output vector (registered) |

## Verification
The bench streams random blocks back to back across several orientation flips. A design that does not flip orientation, or that flips one cycle off, would give a transposed first block and then scrambled or untransposed blocks. Idle cycles are placed at period boundaries and in the middle of a period; a design that let the counter or the output run on an invalid cycle would skip or repeat a slot. A reset in the middle of a block is checked for a fresh N-input priming window, which a leftover primed flag would cut short. Blocks of extreme signed codes catch lane swaps and sign-bit truncation.

// File: rtl/xpb_pkg.sv
package xpb_pkg;
  typedef enum logic {
    ORI_COL = 1'b0,
    ORI_ROW = 1'b1
  } ori_e;
endpackage

// File: rtl/xpb_seq.sv
module xpb_seq #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  output logic [IW-1:0]    idx,
  output xpb_pkg::ori_e    ori,
  output logic             primed
);
  import xpb_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(N - 1);
  logic wrap;
  assign wrap = in_vld && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      ori    <= ORI_COL;
      primed <= 1'b0;
    end else if (in_vld) begin
      if (wrap) begin
        idx    <= '0;
        ori    <= (ori == ORI_COL) ? ORI_ROW : ORI_COL;
        primed <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  p_idx_range_r4: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST);
  p_ori_flip_r4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ori != $past(ori));
  p_ori_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(ori));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(idx));
  p_primed_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    primed |=> primed);
endmodule

// File: rtl/xpb_cell_array.sv
module xpb_cell_array #(
  parameter int N = 4,
  parameter int W = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  xpb_pkg::ori_e                 ori,
  input  logic [IW-1:0]                 idx,
  input  logic [N-1:0][W-1:0]           wr_vec,
  output logic [N-1:0][N-1:0][W-1:0]    cells
);
  import xpb_pkg::*;

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic          hit;
      logic [W-1:0]  d;
      always_comb begin
        if (ori == ORI_COL) begin
          hit = (idx == IW'(c));
          d   = wr_vec[r];
        end else begin
          hit = (idx == IW'(r));
          d   = wr_vec[c];
        end
      end
      always_ff @(posedge clk) begin
        if (wr_en && hit) cells[r][c] <= d;
      end
    end
  end
endmodule

// File: rtl/xpb_read_mux.sv
module xpb_read_mux #(
  parameter int N = 4,
  parameter int W = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int NS = 2 * N - 1,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [N-1:0][N-1:0][W-1:0] cells,
  input  xpb_pkg::ori_e              ori,
  input  logic [IW-1:0]              idx,
  output logic [N-1:0][W-1:0]        rd_vec
);
  import xpb_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [NS-1:0][W-1:0] src;
    logic [SW-1:0]        sel;

    for (genvar j = 0; j < N; j++) begin : g_rowsrc
      assign src[j] = cells[i][j];
    end
    for (genvar j = 0; j < N; j++) begin : g_colsrc
      if (j < i) begin : g_lo
        assign src[N + j] = cells[j][i];
      end else if (j > i) begin : g_hi
        assign src[N + j - 1] = cells[j][i];
      end
    end

    always_comb begin
      if (ori == ORI_COL) begin
        sel = SW'(idx);
      end else if (idx == IW'(i)) begin
        sel = SW'(i);
      end else if (idx < IW'(i)) begin
        sel = SW'(N) + SW'(idx);
      end else begin
        sel = SW'(N - 1) + SW'(idx);
      end
    end

    assign rd_vec[i] = src[sel];
  end
endmodule

// File: rtl/xpose_alt_buffer.sv
module xpose_alt_buffer #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_vld,
  input  logic [N*W-1:0] in_vec,
  output logic           out_vld,
  output logic [N*W-1:0] out_vec
);
  import xpb_pkg::*;

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0]                 idx;
  ori_e                          ori;
  logic                          primed;
  logic [N-1:0][N-1:0][W-1:0]    cells;
  logic [N-1:0][W-1:0]           wr_vec;
  logic [N-1:0][W-1:0]           rd_vec;

  assign wr_vec = in_vec;

  xpb_seq #(.N(N)) u_seq (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .idx(idx), .ori(ori), .primed(primed)
  );

  xpb_cell_array #(.N(N), .W(W)) u_cells (
    .clk(clk), .wr_en(in_vld), .ori(ori), .idx(idx),
    .wr_vec(wr_vec), .cells(cells)
  );

  xpb_read_mux #(.N(N), .W(W)) u_rd (
    .cells(cells), .ori(ori), .idx(idx), .rd_vec(rd_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_vec <= '0;
    end else begin
      out_vld <= in_vld && primed;
      if (in_vld) out_vec <= rd_vec;
    end
  end

  p_idle_no_vld_r5: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
  p_idle_hold_out_r5: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_vec));
  p_vld_needs_prime_r2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !primed) |=> !out_vld);
  p_vld_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && primed) |=> out_vld);
endmodule

// File: tb/tb_xpose_alt_buffer.sv
module tb_xpose_alt_buffer;
  localparam int N = 4;
  localparam int W = 16;
  localparam int HMAX = 1024;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_vld = 1'b0;
  logic [N*W-1:0] in_vec = '0;
  logic           out_vld;
  logic [N*W-1:0] out_vec;

  int checks = 0;
  int fails = 0;
  int nin = 0;
  logic [N*W-1:0] hist [HMAX];
  logic [N*W-1:0] last_out = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xpose_alt_buffer #(.N(N), .W(W)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_vec(in_vec),
    .out_vld(out_vld), .out_vec(out_vec)
  );

  function automatic logic [N*W-1:0] exp_vec(int k);
    logic [N*W-1:0] v;
    int b = k / N;
    int s = k % N;
    for (int j = 0; j < N; j++)
      v[j*W +: W] = hist[(b - 1) * N + j][s*W +: W];
    return v;
  endfunction

  task automatic chk(string req, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [N*W-1:0] d, string req);
    in_vld = v;
    in_vec = d;
    @(posedge clk);
    #1;
    if (v) begin
      if (nin >= N) begin
        chk({req, " R6 vld"}, {{(N*W-1){1'b0}}, out_vld}, 1);
        chk({req, " R3 data"}, out_vec, exp_vec(nin));
      end else begin
        chk("R2 no early vld", {{(N*W-1){1'b0}}, out_vld}, 0);
      end
      hist[nin] = d;
      nin++;
    end else begin
      chk("R5 idle vld", {{(N*W-1){1'b0}}, out_vld}, 0);
      chk("R5 idle hold", out_vec, last_out);
    end
    last_out = out_vec;
  endtask

  function automatic logic [N*W-1:0] rnd_vec();
    logic [N*W-1:0] v;
    for (int j = 0; j < N; j++) v[j*W +: W] = W'($urandom);
    return v;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    in_vld = 1'b0;
    @(posedge clk); @(posedge clk);
    #1;
    chk("R1 rst vld", {{(N*W-1){1'b0}}, out_vld}, 0);
    chk("R1 rst data", out_vec, '0);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 post vld", {{(N*W-1){1'b0}}, out_vld}, 0);
    chk("R1 post data", out_vec, '0);
    nin = 0;
    last_out = out_vec;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int unused;
    unused = $urandom(32'd2024);
    do_reset();

    // R4 R3: back-to-back random blocks over many flips
    for (int k = 0; k < 6 * N; k++) step(1'b1, rnd_vec(), "R4");

    // R7: extreme signed codes, each lane a different extreme
    for (int k = 0; k < N; k++) begin
      logic [N*W-1:0] v;
      for (int j = 0; j < N; j++)
        v[j*W +: W] = ((j + k) % 2 == 0) ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      step(1'b1, v, "R7");
    end
    for (int k = 0; k < N; k++) step(1'b1, rnd_vec(), "R7");

    // R5: gaps at boundaries and mid-period
    for (int k = 0; k < 8 * N; k++) begin
      if (k % 3 == 1) step(1'b0, rnd_vec(), "R5");
      step(1'b1, rnd_vec(), "R5");
    end
    step(1'b0, '0, "R5");
    step(1'b0, '1, "R5");

    // R8: reset mid-block, then priming restarts
    step(1'b1, rnd_vec(), "R8");
    step(1'b1, rnd_vec(), "R8");
    do_reset();
    for (int k = 0; k < 4 * N; k++) step(1'b1, rnd_vec(), "R8");

    // R6 R3: random valid pattern
    for (int k = 0; k < 400; k++) step(($urandom % 4) != 0, rnd_vec(), "R6");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule